// File: doc/BRIEF.md
# 8-bit ALU with Status Flags

This block pairs a combinational 8-bit arithmetic and logic unit with an 8-bit status register. On each cycle in which `op_valid` is high it takes two operands and an operation code, presents the result with a write strobe for the register file, and presents the next status value, which the status register loads at the following rising clock edge. Each operation changes only its own subset of the flags. Compare operations set flags without asking for a result write. Two flag operations set or clear any single status bit.

The carry-in of add-with-carry, subtract-with-carry, compare-with-carry and the rotates is taken from the stored carry flag. The zero flag of the with-carry subtracts is chained, so that a compare of numbers wider than one byte can be run a byte at a time. Register file, instruction decode and branch logic sit outside this block. They read `result`, `result_we` and `flags_q`.

Top module: `sreg_alu`

## Requirements
- R1: Status bits, from 7 down to 0: I, T, H, S, V, N, Z, C. Operation codes: ADD=0, ADC=1, SUB=2, SBC=3, CP=4, CPC=5, AND=6, OR=7, XOR=8, COM=9, NEG=10, INC=11, DEC=12, LSL=13, LSR=14, ROL=15, ROR=16, ASR=17, SWAP=18, FSET=19, FCLR=20. Any other code changes no flag and writes nothing. Reset clears every flag. `flags_q` takes `flags_nx` at each rising edge while `op_valid` is high. While `op_valid` is low, `flags_q` holds and `result_we` is 0.
- R2: ADD gives a+b and ADC gives a+b+C. Both set C from the carry out of bit 7, H from the carry out of bit 3, V on signed overflow, N from result bit 7, Z on a zero result, and S.
- R3: SUB gives a-b and SBC gives a-b-C. C is the borrow out of bit 7 and H is the borrow out of bit 3. V is signed overflow. N, Z and S are updated.
- R4: For SBC and CPC, Z becomes 1 only when the result is zero and Z was already 1. Otherwise Z becomes 0.
- R5: CP and CPC set the flags as SUB and SBC would, and hold `result_we` at 0.
- R6: AND, OR and XOR write the bitwise result, clear V, and update N, Z and S. C and H keep their values.
- R7: COM writes 0xFF minus a, sets C to 1, clears V, updates N, Z and S, and keeps H.
- R8: NEG writes 0x00 minus a. C is 1 when the result is nonzero, V is 1 when the result is 0x80, and H is the borrow out of bit 3. N, Z and S are updated.
- R9: INC and DEC write a+1 and a-1. V is 1 when the result is 0x80 (INC) or 0x7F (DEC). N, Z and S are updated. C and H keep their values.
- R10: LSL and LSR shift in a zero. ROL and ROR shift the old C in. ASR keeps bit 7. In each case the bit shifted out goes to C, V = N xor C, N, Z and S are updated, and H is kept.
- R11: SWAP writes a with bits 7:4 and 3:0 exchanged and changes no flag.
- R12: FSET sets and FCLR clears only the flag whose index is in `opb[2:0]`. Both hold `result_we` at 0.
- R13: After every arithmetic, logic or shift operation, S equals N xor V. I and T change only through FSET and FCLR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | The operation on `op_code` is executed this cycle |
| op_code | input | 5 | Operation select (codes in R1) |
| opa | input | 8 | First operand (the only operand of unary operations) |
| opb | input | 8 | Second operand. Bits 2:0 give the flag index for FSET and FCLR |
| result | output | 8 | Operation result |
| result_we | output | 1 | The register file should store `result` |
| flags_nx | output | 8 | Status value that will be loaded at the next edge |
| flags_q | output | 8 | Stored status register |

## Verification
A vector table loads a chosen starting status before each operation, so every flag that is meant to be kept is seen to survive. The operand patterns target the points where flag rules differ:
- carries out of bit 3 alone and out of bit 7 alone, and signed overflow in both directions;
- a borrow that wraps to 0xFF;
- zero results of the with-carry subtracts with the prior Z both set and clear, which separates a chained zero from a plain one;
- 0x80 and 0x7F at the INC, DEC and NEG boundaries;
- shifts and rotates whose outgoing bit differs from the carry coming in.

Directed tests then check reset, a reset applied after the flags were loaded, and an idle cycle with a live operation code present. Together these separate a held status from a silently updated one.

// File: rtl/sreg_alu_pkg.sv
package sreg_alu_pkg;

    localparam int FLAG_W = 8;

    // status bit positions
    localparam int FL_C = 0;
    localparam int FL_Z = 1;
    localparam int FL_N = 2;
    localparam int FL_V = 3;
    localparam int FL_S = 4;
    localparam int FL_H = 5;
    localparam int FL_T = 6;
    localparam int FL_I = 7;

    typedef enum logic [4:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SBC  = 5'd3,
        OP_CP   = 5'd4,
        OP_CPC  = 5'd5,
        OP_AND  = 5'd6,
        OP_OR   = 5'd7,
        OP_XOR  = 5'd8,
        OP_COM  = 5'd9,
        OP_NEG  = 5'd10,
        OP_INC  = 5'd11,
        OP_DEC  = 5'd12,
        OP_LSL  = 5'd13,
        OP_LSR  = 5'd14,
        OP_ROL  = 5'd15,
        OP_ROR  = 5'd16,
        OP_ASR  = 5'd17,
        OP_SWAP = 5'd18,
        OP_FSET = 5'd19,
        OP_FCLR = 5'd20
    } op_e;

    typedef struct packed {
        logic [FLAG_W-1:0] flags;
    } stat_s;

endpackage

// File: rtl/sreg_alu_addsub.sv
module sreg_alu_addsub #(
    parameter int DATA_W = 8,
    parameter int NIB_W  = 4
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              cin_i,
    input  logic              sub_i,
    output logic [DATA_W-1:0] res_o,
    output logic              cout_o,
    output logic              half_o,
    output logic              ovf_o
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W:0] wide;
    logic [NIB_W:0]  low;

    always_comb begin
        if (sub_i) begin
            wide = {1'b0, a_i} - {1'b0, b_i} - {{DATA_W{1'b0}}, cin_i};
            low  = {1'b0, a_i[NIB_W-1:0]} - {1'b0, b_i[NIB_W-1:0]} - {{NIB_W{1'b0}}, cin_i};
        end else begin
            wide = {1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, cin_i};
            low  = {1'b0, a_i[NIB_W-1:0]} + {1'b0, b_i[NIB_W-1:0]} + {{NIB_W{1'b0}}, cin_i};
        end
        res_o  = wide[DATA_W-1:0];
        cout_o = wide[DATA_W];
        half_o = low[NIB_W];
        if (sub_i)
            ovf_o = (a_i[MSB] != b_i[MSB]) && (res_o[MSB] != a_i[MSB]);
        else
            ovf_o = (a_i[MSB] == b_i[MSB]) && (res_o[MSB] != a_i[MSB]);
    end

endmodule

// File: rtl/sreg_alu_logic.sv
module sreg_alu_logic
    import sreg_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  op_e               op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] res_o
);
    localparam int HALF = DATA_W / 2;

    always_comb begin
        unique case (op_i)
            OP_AND:  res_o = a_i & b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            OP_COM:  res_o = ~a_i;
            OP_SWAP: res_o = {a_i[HALF-1:0], a_i[DATA_W-1:HALF]};
            default: res_o = a_i;
        endcase
    end

endmodule

// File: rtl/sreg_alu_shift.sv
module sreg_alu_shift
    import sreg_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  op_e               op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic              cin_i,
    output logic [DATA_W-1:0] res_o,
    output logic              cout_o
);
    localparam int MSB = DATA_W - 1;

    always_comb begin
        unique case (op_i)
            OP_LSL: begin res_o = {a_i[MSB-1:0], 1'b0};   cout_o = a_i[MSB]; end
            OP_ROL: begin res_o = {a_i[MSB-1:0], cin_i};  cout_o = a_i[MSB]; end
            OP_LSR: begin res_o = {1'b0, a_i[MSB:1]};     cout_o = a_i[0];   end
            OP_ROR: begin res_o = {cin_i, a_i[MSB:1]};    cout_o = a_i[0];   end
            OP_ASR: begin res_o = {a_i[MSB], a_i[MSB:1]}; cout_o = a_i[0];   end
            default: begin res_o = a_i; cout_o = cin_i; end
        endcase
    end

endmodule

// File: rtl/sreg_alu.sv
module sreg_alu
    import sreg_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [4:0]        op_code,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] result,
    output logic              result_we,
    output logic [FLAG_W-1:0] flags_nx,
    output logic [FLAG_W-1:0] flags_q
);
    localparam int MSB   = DATA_W - 1;
    localparam int IDX_W = $clog2(FLAG_W);

    stat_s st_d, st_q;
    op_e   op_s;

    logic [DATA_W-1:0] as_a, as_b, as_res, lg_res, sh_res;
    logic              as_cin, as_sub, as_cout, as_half, as_ovf, sh_cout;
    logic [DATA_W-1:0] res_d;
    logic              we_d;
    logic [FLAG_W-1:0] fl;

    assign op_s = op_e'(op_code);

    // operand routing for the shared adder/subtractor
    always_comb begin
        as_a   = opa;
        as_b   = opb;
        as_cin = 1'b0;
        as_sub = 1'b0;
        case (op_s)
            OP_ADC: as_cin = st_q.flags[FL_C];
            OP_SUB, OP_CP: as_sub = 1'b1;
            OP_SBC, OP_CPC: begin
                as_sub = 1'b1;
                as_cin = st_q.flags[FL_C];
            end
            OP_NEG: begin
                as_a   = '0;
                as_b   = opa;
                as_sub = 1'b1;
            end
            OP_INC: as_b = DATA_W'(1);
            OP_DEC: begin
                as_b   = DATA_W'(1);
                as_sub = 1'b1;
            end
            default: ;
        endcase
    end

    sreg_alu_addsub #(.DATA_W(DATA_W), .NIB_W(4)) addsub_i (
        .a_i    (as_a),
        .b_i    (as_b),
        .cin_i  (as_cin),
        .sub_i  (as_sub),
        .res_o  (as_res),
        .cout_o (as_cout),
        .half_o (as_half),
        .ovf_o  (as_ovf)
    );

    sreg_alu_logic #(.DATA_W(DATA_W)) logic_i (
        .op_i  (op_s),
        .a_i   (opa),
        .b_i   (opb),
        .res_o (lg_res)
    );

    sreg_alu_shift #(.DATA_W(DATA_W)) shift_i (
        .op_i   (op_s),
        .a_i    (opa),
        .cin_i  (st_q.flags[FL_C]),
        .res_o  (sh_res),
        .cout_o (sh_cout)
    );

    // next-state computation
    always_comb begin
        st_d  = st_q;
        fl    = st_q.flags;
        res_d = as_res;
        we_d  = 1'b0;
        case (op_s)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CP, OP_CPC, OP_NEG: begin
                res_d    = as_res;
                we_d     = !(op_s == OP_CP || op_s == OP_CPC);
                fl[FL_H] = as_half;
                fl[FL_C] = as_cout;
                fl[FL_V] = as_ovf;
                fl[FL_N] = res_d[MSB];
                if (op_s == OP_SBC || op_s == OP_CPC)
                    fl[FL_Z] = (res_d == '0) && st_q.flags[FL_Z];
                else
                    fl[FL_Z] = (res_d == '0);
                fl[FL_S] = fl[FL_N] ^ fl[FL_V];
            end
            OP_INC, OP_DEC: begin
                res_d    = as_res;
                we_d     = 1'b1;
                fl[FL_V] = as_ovf;
                fl[FL_N] = res_d[MSB];
                fl[FL_Z] = (res_d == '0);
                fl[FL_S] = fl[FL_N] ^ fl[FL_V];
            end
            OP_AND, OP_OR, OP_XOR, OP_COM: begin
                res_d    = lg_res;
                we_d     = 1'b1;
                fl[FL_V] = 1'b0;
                fl[FL_N] = res_d[MSB];
                fl[FL_Z] = (res_d == '0);
                fl[FL_S] = fl[FL_N];
                if (op_s == OP_COM)
                    fl[FL_C] = 1'b1;
            end
            OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR: begin
                res_d    = sh_res;
                we_d     = 1'b1;
                fl[FL_C] = sh_cout;
                fl[FL_N] = res_d[MSB];
                fl[FL_Z] = (res_d == '0);
                fl[FL_V] = fl[FL_N] ^ fl[FL_C];
                fl[FL_S] = fl[FL_N] ^ fl[FL_V];
            end
            OP_SWAP: begin
                res_d = lg_res;
                we_d  = 1'b1;
            end
            OP_FSET: fl[opb[IDX_W-1:0]] = 1'b1;
            OP_FCLR: fl[opb[IDX_W-1:0]] = 1'b0;
            default: ;
        endcase
        if (op_valid)
            st_d.flags = fl;
        else
            we_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign result    = res_d;
    assign result_we = we_d;
    assign flags_nx  = st_d.flags;
    assign flags_q   = st_q.flags;

endmodule

// File: rtl/sreg_alu_chk.sv
module sreg_alu_chk
    import sreg_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [4:0]        op_code,
    input logic [DATA_W-1:0] opb,
    input logic              result_we,
    input logic [FLAG_W-1:0] flags_nx,
    input logic [FLAG_W-1:0] flags_q
);
    logic is_arith, is_flagop;
    assign is_arith  = op_valid && (op_code <= 5'd17);
    assign is_flagop = (op_code == OP_FSET) || (op_code == OP_FCLR);

    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(flags_q));

    // R1
    idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |-> !result_we);

    // R1
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> flags_q == $past(flags_nx));

    // R4
    zero_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && (op_code == OP_SBC || op_code == OP_CPC) && !flags_q[FL_Z] |=> !flags_q[FL_Z]);

    // R5
    cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && (op_code == OP_CP || op_code == OP_CPC) |-> !result_we);

    // R9
    incdec_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && (op_code == OP_INC || op_code == OP_DEC) |=> flags_q[FL_C] == $past(flags_q[FL_C]));

    // R11
    swap_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_code == OP_SWAP |=> flags_q == $past(flags_q));

    // R12
    flagop_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && is_flagop |-> !result_we);

    // R13
    sign_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_arith |=> flags_q[FL_S] == (flags_q[FL_N] ^ flags_q[FL_V]));

    // R13
    it_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_arith |=> flags_q[FL_I:FL_T] == $past(flags_q[FL_I:FL_T]));

endmodule

bind sreg_alu sreg_alu_chk #(.DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .opb       (opb),
    .result_we (result_we),
    .flags_nx  (flags_nx),
    .flags_q   (flags_q)
);

// File: tb/sreg_alu_tb.sv
module sreg_alu_tb_top;
    import sreg_alu_pkg::*;

    localparam int CLK_P = 10;
    localparam int NV    = 38;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [4:0] op_code = '0;
    logic [7:0] opa = '0, opb = '0;
    logic [7:0] result, flags_nx, flags_q;
    logic       result_we;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    sreg_alu #(.DATA_W(8)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .op_code   (op_code),
        .opa       (opa),
        .opb       (opb),
        .result    (result),
        .result_we (result_we),
        .flags_nx  (flags_nx),
        .flags_q   (flags_q)
    );

    // fields: req(4) op(5) a(8) b(8) flags_in(8) result(8) we(1) flags_out(8)
    // flag bits: I7 T6 H5 S4 V3 N2 Z1 C0
    localparam logic [49:0] VEC [NV] = '{
        {4'd2,  OP_ADD,  8'h0F, 8'h01, 8'h00, 8'h10, 1'b1, 8'h20}, // R2 half carry only
        {4'd2,  OP_ADD,  8'h80, 8'h80, 8'hC0, 8'h00, 1'b1, 8'hDB}, // R2 carry, overflow, zero
        {4'd2,  OP_ADC,  8'h7F, 8'h00, 8'h01, 8'h80, 1'b1, 8'h2C}, // R2 carry in
        {4'd3,  OP_SUB,  8'h10, 8'h01, 8'h00, 8'h0F, 1'b1, 8'h20}, // R3 half borrow
        {4'd3,  OP_SUB,  8'h00, 8'h01, 8'h00, 8'hFF, 1'b1, 8'h35}, // R3 wrap
        {4'd13, OP_SUB,  8'h80, 8'h01, 8'h00, 8'h7F, 1'b1, 8'h38}, // R13 S from V
        {4'd4,  OP_SBC,  8'h05, 8'h05, 8'h02, 8'h00, 1'b1, 8'h02}, // R4 Z kept
        {4'd4,  OP_SBC,  8'h05, 8'h05, 8'h00, 8'h00, 1'b1, 8'h00}, // R4 Z not set
        {4'd4,  OP_SBC,  8'h05, 8'h04, 8'h03, 8'h00, 1'b1, 8'h02}, // R4 borrow in
        {4'd3,  OP_SBC,  8'h05, 8'h05, 8'h03, 8'hFF, 1'b1, 8'h35}, // R3 borrow in
        {4'd5,  OP_CP,   8'h42, 8'h42, 8'h00, 8'h00, 1'b0, 8'h02}, // R5
        {4'd5,  OP_CP,   8'h01, 8'h02, 8'h00, 8'h00, 1'b0, 8'h35}, // R5
        {4'd5,  OP_CPC,  8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00}, // R5 chain clear
        {4'd4,  OP_CPC,  8'h00, 8'h00, 8'h02, 8'h00, 1'b0, 8'h02}, // R4 chain kept
        {4'd6,  OP_AND,  8'hF0, 8'h3C, 8'h29, 8'h30, 1'b1, 8'h21}, // R6 C,H kept, V cleared
        {4'd6,  OP_AND,  8'h0F, 8'hF0, 8'h00, 8'h00, 1'b1, 8'h02}, // R6
        {4'd6,  OP_OR,   8'h80, 8'h01, 8'h08, 8'h81, 1'b1, 8'h14}, // R6
        {4'd6,  OP_XOR,  8'hAA, 8'hAA, 8'hE1, 8'h00, 1'b1, 8'hE3}, // R6
        {4'd7,  OP_COM,  8'h55, 8'h00, 8'h00, 8'hAA, 1'b1, 8'h15}, // R7
        {4'd7,  OP_COM,  8'hFF, 8'h00, 8'h20, 8'h00, 1'b1, 8'h23}, // R7
        {4'd8,  OP_NEG,  8'h01, 8'h00, 8'h00, 8'hFF, 1'b1, 8'h35}, // R8
        {4'd8,  OP_NEG,  8'h80, 8'h00, 8'h00, 8'h80, 1'b1, 8'h0D}, // R8 overflow
        {4'd8,  OP_NEG,  8'h00, 8'h00, 8'h01, 8'h00, 1'b1, 8'h02}, // R8 zero
        {4'd9,  OP_INC,  8'h7F, 8'h00, 8'h01, 8'h80, 1'b1, 8'h0D}, // R9
        {4'd9,  OP_INC,  8'hFF, 8'h00, 8'h00, 8'h00, 1'b1, 8'h02}, // R9 no carry
        {4'd9,  OP_DEC,  8'h80, 8'h00, 8'h20, 8'h7F, 1'b1, 8'h38}, // R9
        {4'd9,  OP_DEC,  8'h01, 8'h00, 8'h01, 8'h00, 1'b1, 8'h03}, // R9
        {4'd10, OP_LSL,  8'h81, 8'h00, 8'h00, 8'h02, 1'b1, 8'h19}, // R10
        {4'd10, OP_LSL,  8'h40, 8'h00, 8'h01, 8'h80, 1'b1, 8'h0C}, // R10 zero fill
        {4'd10, OP_LSR,  8'h01, 8'h00, 8'h00, 8'h00, 1'b1, 8'h1B}, // R10
        {4'd10, OP_ROL,  8'h80, 8'h00, 8'h01, 8'h01, 1'b1, 8'h19}, // R10
        {4'd10, OP_ROR,  8'h01, 8'h00, 8'h01, 8'h80, 1'b1, 8'h15}, // R10
        {4'd10, OP_ROR,  8'h02, 8'h00, 8'h00, 8'h01, 1'b1, 8'h00}, // R10
        {4'd10, OP_ASR,  8'h81, 8'h00, 8'h00, 8'hC0, 1'b1, 8'h15}, // R10
        {4'd11, OP_SWAP, 8'h3C, 8'h00, 8'hA5, 8'hC3, 1'b1, 8'hA5}, // R11
        {4'd12, OP_FSET, 8'h00, 8'h06, 8'h00, 8'h00, 1'b0, 8'h40}, // R12 set T
        {4'd12, OP_FCLR, 8'h00, 8'h00, 8'hFF, 8'h00, 1'b0, 8'hFE}, // R12 clear C
        {4'd1,  5'd31,   8'h12, 8'h34, 8'h5A, 8'h00, 1'b0, 8'h5A}  // R1 unused code
    };

    task automatic chk(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic load_flags(input logic [7:0] f);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            op_valid = 1'b1;
            op_code  = f[i] ? OP_FSET : OP_FCLR;
            opb      = 8'(i);
        end
    endtask

    task automatic run_vec(input logic [49:0] v);
        string tag;
        tag = $sformatf("R%0d", v[49:46]);
        load_flags(v[24:17]);
        @(negedge clk);
        op_valid = 1'b1;
        op_code  = v[45:41];
        opa      = v[40:33];
        opb      = v[32:25];
        #(CLK_P/4);
        chk(tag, "result_we", {7'd0, result_we}, {7'd0, v[8]});
        if (v[8]) chk(tag, "result", result, v[16:9]);
        chk(tag, "flags_nx", flags_nx, v[7:0]);
        @(posedge clk);
        #1;
        chk(tag, "flags_q", flags_q, v[7:0]);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "reset flags", flags_q, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) run_vec(VEC[i]);

        // R1 idle cycle with a live opcode
        load_flags(8'h5A);
        @(negedge clk);
        op_valid = 1'b0;
        op_code  = OP_ADD;
        opa      = 8'hFF;
        opb      = 8'h01;
        #(CLK_P/4);
        chk("R1", "idle result_we", {7'd0, result_we}, 8'h00);
        chk("R1", "idle flags_nx", flags_nx, 8'h5A);
        @(posedge clk);
        #1;
        chk("R1", "idle flags_q", flags_q, 8'h5A);

        // R1 reset after flags loaded
        load_flags(8'hFF);
        @(negedge clk);
        op_valid = 1'b0;
        #1;
        chk("R1", "loaded flags", flags_q, 8'hFF);
        rst_n = 1'b0;
        #1;
        chk("R1", "async reset", flags_q, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule